// File: doc/BRIEF.md
# Redundant Packet Copy Selector

This block sits on the receive side of a ring network node, between the link checker and the local memory write port. Each incoming packet is one beat. It carries a payload, an error flag raised by the link checker, and a tag that marks it as the first or the second copy of a transmission. The block decides which packets may update local memory. It presents the chosen packets on a memory-write request stream, and it keeps a sticky bad-data status bit that the host can clear.

A static mode input selects one of two modes. In fast mode each packet is sent once: a clean packet is forwarded and a damaged one is dropped. In redundant mode every packet arrives as two copies, whatever its payload size. The first error-free copy is written and the other copy is discarded. When both copies are damaged, the packet is removed entirely. Any damaged copy sets the status bit, even when the other copy rescues the packet. Copies are paired strictly in arrival order. The block keeps only the state of one open pair, so it never stores a copy's payload.

Top module: `rx_copy_select`

## Requirements
- R1: In fast mode (`redundant` = 0), a packet with `in_err` = 0 that is accepted on a clock edge appears on `out_data` with `out_valid` = 1 right after that edge.
- R2: In fast mode, a packet accepted with `in_err` = 1 is never presented on the output, and it sets the bad-data bit.
- R3: In redundant mode (`redundant` = 1, `in_dup` = 0 for the first copy and 1 for the second), an error-free first copy is forwarded right after its acceptance edge, and the matching second copy is discarded.
- R4: In redundant mode, when the first copy has `in_err` = 1 and the second copy has `in_err` = 0, the second copy's payload is forwarded right after its acceptance edge.
- R5: In redundant mode, when both copies of a pair have `in_err` = 1, nothing is forwarded for that pair.
- R6: The bad-data bit is bit 1 of `status_word`, and every other bit of `status_word` reads 0. The bit is set after any accepted copy with `in_err` = 1 in either mode, including a damaged copy whose partner was forwarded.
- R7: The bad-data bit is sticky. It clears only after a host write (`host_wr` = 1) with `host_wdata` bit 1 = 1. A host write with bit 1 = 0 leaves it unchanged. A new error event in the same cycle as a clearing write leaves the bit set.
- R8: Pairing follows arrival order. A first copy that arrives while a pair is open closes the open pair as an error (the bad-data bit is set) and opens a new pair. A second copy that arrives with no open pair is discarded and sets the bad-data bit.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` = 1 and `out_ready` = 0, `out_data` and `out_valid` hold their values.
- R10: During and just after reset, `out_valid` = 0, `status_word` = 0, `in_ready` = 1, and no pair is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redundant | input | 1 | Static mode: 1 = each packet is sent as two copies, 0 = each packet is sent once |
| in_valid | input | 1 | Incoming packet beat is valid |
| in_ready | output | 1 | Block accepts the incoming beat this cycle |
| in_data | input | PKT_W | Packet payload |
| in_err | input | 1 | Link checker found an error in this copy |
| in_dup | input | 1 | Copy tag: 0 = first copy, 1 = second copy (used in redundant mode only) |
| out_valid | output | 1 | Memory-write request valid |
| out_ready | input | 1 | Memory side takes the request |
| out_data | output | PKT_W | Payload to write |
| host_wr | input | 1 | Host write strobe to the status word |
| host_wdata | input | STAT_W | Host write data; a 1 in bit 1 clears the bad-data bit |
| status_word | output | STAT_W | Status word; bit 1 is the sticky bad-data bit |

## Verification
The selector is driven with every good/bad combination of a copy pair: clean/clean, bad/clean, bad/bad and clean/bad. These show whether the first or the second payload is written, or nothing, and whether the status bit follows errors in either copy. Orphaned first copies and stray second copies separate strict arrival-order pairing from pairing that tolerates gaps. Fast-mode clean and damaged packets are run, together with an output stall and a long mixed stream with a toggling memory-side ready. These check the one-cycle forwarding and the stall-hold behaviour. Host writes with and without bit 1, including one in the same cycle as an error, check the sticky clear and its priority.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic {
        PAIR_IDLE = 1'b0,
        PAIR_OPEN = 1'b1
    } pair_e;

    typedef struct packed {
        pair_e st;
        logic  first_ok;
    } pair_s;

    typedef struct packed {
        logic bad;
    } flag_s;

endpackage

// File: rtl/rcs_pair_ctrl.sv
module rcs_pair_ctrl
    import rcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic redundant,
    input  logic beat_acc,
    input  logic beat_err,
    input  logic beat_dup,
    output logic take,
    output logic bad_evt,
    output logic pair_open
);

    pair_s pair_q, pair_d;

    always_comb begin
        pair_d  = pair_q;
        take    = 1'b0;
        bad_evt = 1'b0;
        if (!redundant) begin
            pair_d.st       = PAIR_IDLE;
            pair_d.first_ok = 1'b0;
            if (beat_acc) begin
                take    = !beat_err;
                bad_evt = beat_err;
            end
        end else if (beat_acc) begin
            if (!beat_dup) begin
                // a new first copy; an open pair left behind is an error
                take            = !beat_err;
                bad_evt         = beat_err || (pair_q.st == PAIR_OPEN);
                pair_d.st       = PAIR_OPEN;
                pair_d.first_ok = !beat_err;
            end else if (pair_q.st == PAIR_OPEN) begin
                take            = !pair_q.first_ok && !beat_err;
                bad_evt         = beat_err;
                pair_d.st       = PAIR_IDLE;
                pair_d.first_ok = 1'b0;
            end else begin
                // second copy without a partner
                bad_evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q.st       <= PAIR_IDLE;
            pair_q.first_ok <= 1'b0;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign pair_open = (pair_q.st == PAIR_OPEN);

endmodule

// File: rtl/rcs_out_stage.sv
module rcs_out_stage #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          sink_ready,
    output logic          slot_free,
    output logic          req_valid,
    output logic [DW-1:0] req_data
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } slot_s;

    slot_s slot_q, slot_d;

    assign slot_free = !slot_q.vld || sink_ready;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.vld && sink_ready) begin
            slot_d.vld = 1'b0;
        end
        if (load) begin
            slot_d.vld  = 1'b1;
            slot_d.data = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q.vld  <= 1'b0;
            slot_q.data <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign req_valid = slot_q.vld;
    assign req_data  = slot_q.data;

endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
    import rcs_pkg::*;
#(
    parameter int SW      = 32,
    parameter int BAD_POS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_evt,
    input  logic          host_wr,
    input  logic [SW-1:0] host_wdata,
    output logic [SW-1:0] word
);

    flag_s flag_q, flag_d;

    always_comb begin
        flag_d = flag_q;
        if (set_evt) begin
            flag_d.bad = 1'b1;
        end else if (host_wr && host_wdata[BAD_POS]) begin
            flag_d.bad = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q.bad <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    always_comb begin
        word          = '0;
        word[BAD_POS] = flag_q.bad;
    end

endmodule

// File: rtl/rx_copy_select.sv
module rx_copy_select #(
    parameter int PKT_W  = 64,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redundant,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PKT_W-1:0]  in_data,
    input  logic              in_err,
    input  logic              in_dup,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PKT_W-1:0]  out_data,
    input  logic              host_wr,
    input  logic [STAT_W-1:0] host_wdata,
    output logic [STAT_W-1:0] status_word
);

    localparam int BAD_POS = 1;

    logic beat_acc;
    logic take;
    logic bad_evt;
    logic pair_open;

    assign beat_acc = in_valid && in_ready;

    rcs_pair_ctrl u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .redundant (redundant),
        .beat_acc  (beat_acc),
        .beat_err  (in_err),
        .beat_dup  (in_dup),
        .take      (take),
        .bad_evt   (bad_evt),
        .pair_open (pair_open)
    );

    rcs_out_stage #(.DW(PKT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take),
        .load_data  (in_data),
        .sink_ready (out_ready),
        .slot_free  (in_ready),
        .req_valid  (out_valid),
        .req_data   (out_data)
    );

    rcs_status_reg #(.SW(STAT_W), .BAD_POS(BAD_POS)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_evt    (bad_evt),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .word       (status_word)
    );

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int PKT_W  = 64,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redundant,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PKT_W-1:0]  in_data,
    input logic              in_err,
    input logic              in_dup,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PKT_W-1:0]  out_data,
    input logic              host_wr,
    input logic [STAT_W-1:0] host_wdata,
    input logic [STAT_W-1:0] status_word,
    input logic              pair_open
);

    logic acc;
    logic first_err_q;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_err_q <= 1'b0;
        end else if (redundant && acc && !in_dup) begin
            first_err_q <= in_err;
        end
    end

    // R1
    p_fast_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!redundant && acc && !in_err) |=> (out_valid && out_data == $past(in_data)));

    // R2
    p_fast_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redundant && acc && in_err) |=> status_word[1]);

    // R4
    p_rescue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redundant && acc && in_dup && pair_open && first_err_q && !in_err)
        |=> (out_valid && out_data == $past(in_data)));

    // R5
    p_both_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (redundant && acc && in_dup && pair_open && first_err_q && in_err) |=> !out_valid);

    // R7
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[1] && !(host_wr && host_wdata[1])) |=> status_word[1]);

    // R9
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind rx_copy_select rcs_checker #(.PKT_W(PKT_W), .STAT_W(STAT_W)) u_rcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .redundant   (redundant),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .in_err      (in_err),
    .in_dup      (in_dup),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .status_word (status_word),
    .pair_open   (pair_open)
);

// File: tb/rx_copy_select_bench.sv
module rx_copy_select_bench;

    localparam int PW = 64;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          redundant = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_data = '0;
    logic          in_err = 1'b0;
    logic          in_dup = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [PW-1:0] out_data;
    logic          host_wr = 1'b0;
    logic [SW-1:0] host_wdata = '0;
    logic [SW-1:0] status_word;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit stress = 0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    rx_copy_select #(.PKT_W(PW), .STAT_W(SW)) u_rx_copy_select (
        .clk(clk), .rst_n(rst_n), .redundant(redundant),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_err(in_err), .in_dup(in_dup),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .host_wr(host_wr), .host_wdata(host_wdata), .status_word(status_word)
    );

    // behavioural reference state
    bit            m_ov = 0;
    logic [PW-1:0] m_od = '0;
    bit            m_bad = 0;
    bit            m_open = 0;
    bit            m_first_good = 0;
    logic [PW-1:0] wr_log[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ov = 0; m_bad = 0; m_open = 0; m_first_good = 0;
        end else begin
            bit acc, fwd, err_ev;
            acc = in_valid && (!m_ov || out_ready);
            fwd = 0; err_ev = 0;
            if (out_valid && out_ready) wr_log.push_back(out_data);
            if (m_ov && out_ready) m_ov = 0;
            if (acc) begin
                if (!redundant) begin
                    fwd = !in_err; err_ev = in_err;
                end else if (!in_dup) begin
                    err_ev = in_err || m_open;
                    fwd = !in_err;
                    m_open = 1; m_first_good = !in_err;
                end else if (m_open) begin
                    err_ev = in_err;
                    fwd = !m_first_good && !in_err;
                    m_open = 0;
                end else begin
                    err_ev = 1;
                end
            end
            if (!redundant) m_open = 0;
            if (fwd) begin m_ov = 1; m_od = in_data; end
            if (err_ev) m_bad = 1;
            else if (host_wr && host_wdata[1]) m_bad = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            logic [SW-1:0] es;
            es = '0;
            es[1] = m_bad;
            check(out_valid === m_ov, cur_req, "model out_valid", PW'(out_valid), PW'(m_ov));
            if (m_ov) check(out_data === m_od, cur_req, "model out_data", out_data, m_od);
            check(in_ready === (!m_ov || out_ready), cur_req, "model in_ready",
                  PW'(in_ready), PW'(!m_ov || out_ready));
            check(status_word === es, cur_req, "model status_word", PW'(status_word), PW'(es));
        end
    end

    // toggling memory-side ready during the stress run
    int tick = 0;
    always @(negedge clk) begin
        tick++;
        if (stress) out_ready <= (tick % 5) != 2 && (tick % 7) != 3;
    end

    task automatic send(input logic [PW-1:0] d, input bit e, input bit dup);
        @(negedge clk);
        in_valid = 1; in_data = d; in_err = e; in_dup = dup;
        @(posedge clk);
        while (!in_ready) @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic hwrite(input logic [SW-1:0] w);
        @(negedge clk);
        host_wr = 1; host_wdata = w;
        @(negedge clk);
        host_wr = 0; host_wdata = '0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_log(input string req, input int n,
                              input logic [PW-1:0] a, input logic [PW-1:0] b);
        check(wr_log.size() == n, req, "write count", PW'(wr_log.size()), PW'(n));
        if (n > 0 && wr_log.size() > 0) check(wr_log[0] === a, req, "first write", wr_log[0], a);
        if (n > 1 && wr_log.size() > 1) check(wr_log[1] === b, req, "second write", wr_log[1], b);
        wr_log.delete();
    endtask

    task automatic expect_stat(input string req, input logic [SW-1:0] e);
        check(status_word === e, req, "status_word", PW'(status_word), PW'(e));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R10", "out_valid in reset", PW'(out_valid), 0);
        check(status_word === '0, "R10", "status in reset", PW'(status_word), 0);
        rst_n = 1;
        @(negedge clk);
        check(in_ready === 1'b1, "R10", "in_ready after reset", PW'(in_ready), 1);
        check(out_valid === 1'b0, "R10", "out_valid after reset", PW'(out_valid), 0);

        // R1 fast clean packet, forwarded right after acceptance
        cur_req = "R1";
        send(64'hA1A1_0000_0000_0001, 0, 0);
        #5;
        check(out_valid === 1'b1, "R1", "out_valid after accept", PW'(out_valid), 1);
        check(out_data === 64'hA1A1_0000_0000_0001, "R1", "out_data", out_data, 64'hA1A1_0000_0000_0001);
        idle(); settle();
        expect_log("R1", 1, 64'hA1A1_0000_0000_0001, '0);

        // R2 fast damaged packet dropped
        cur_req = "R2";
        send(64'hB2, 1, 0); idle(); settle();
        expect_log("R2", 0, '0, '0);
        expect_stat("R2", 32'h2);

        // R7 clear only with bit 1
        cur_req = "R7";
        hwrite(32'hFFFF_FFFD); settle();
        expect_stat("R7", 32'h2);
        hwrite(32'h0000_0002); settle();
        expect_stat("R7", 32'h0);

        // R3 clean pair
        cur_req = "R3";
        redundant = 1;
        send(64'hC3, 0, 0); send(64'hC3, 0, 1); idle(); settle();
        expect_log("R3", 1, 64'hC3, '0);
        expect_stat("R3", 32'h0);

        // R4 bad first, good second
        cur_req = "R4";
        send(64'hD401, 1, 0); send(64'hD402, 0, 1); idle(); settle();
        expect_log("R4", 1, 64'hD402, '0);
        expect_stat("R4", 32'h2);
        hwrite(32'h2);

        // R5 both bad
        cur_req = "R5";
        send(64'hE5, 1, 0); send(64'hE5, 1, 1); idle(); settle();
        expect_log("R5", 0, '0, '0);
        expect_stat("R5", 32'h2);
        hwrite(32'h2);

        // R6 good first, bad second still flags
        cur_req = "R6";
        send(64'hF6, 0, 0); send(64'hF6, 1, 1); idle(); settle();
        expect_log("R6", 1, 64'hF6, '0);
        expect_stat("R6", 32'h2);
        hwrite(32'h2);

        // R8 orphaned first copy, then stray second copy
        cur_req = "R8";
        send(64'h1008, 0, 0); send(64'h2008, 0, 0); send(64'h2008, 0, 1); idle(); settle();
        expect_log("R8", 2, 64'h1008, 64'h2008);
        expect_stat("R8", 32'h2);
        hwrite(32'h2);
        send(64'h3008, 0, 1); idle(); settle();
        expect_log("R8", 0, '0, '0);
        expect_stat("R8", 32'h2);
        hwrite(32'h2);

        // R9 output stall
        cur_req = "R9";
        redundant = 0;
        out_ready = 0;
        send(64'h9009, 0, 0); idle();
        repeat (4) begin
            @(negedge clk);
            check(out_valid === 1'b1 && out_data === 64'h9009, "R9", "held output", out_data, 64'h9009);
            check(in_ready === 1'b0, "R9", "in_ready during stall", PW'(in_ready), 0);
        end
        out_ready = 1; settle();
        expect_log("R9", 1, 64'h9009, '0);

        // R7 error and clear in the same cycle: error wins
        cur_req = "R7";
        @(negedge clk);
        in_valid = 1; in_data = 64'h7007; in_err = 1; in_dup = 0;
        host_wr = 1; host_wdata = 32'h2;
        @(negedge clk);
        in_valid = 0; host_wr = 0; host_wdata = '0;
        settle();
        expect_stat("R7", 32'h2);
        hwrite(32'h2);

        // mixed stream with toggling ready
        cur_req = "R9";
        redundant = 1;
        stress = 1;
        for (int i = 0; i < 60; i++) begin
            send(PW'(64'h5000 + i), (i % 3) == 1, 0);
            if ((i % 11) != 4) send(PW'(64'h6000 + i), (i % 4) == 2, 1);
            if ((i % 6) == 5) idle();
            if ((i % 13) == 7) hwrite(32'h2);
        end
        idle();
        stress = 0;
        out_ready = 1;
        settle();
        wr_log.delete();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule